// File: doc/BRIEF.md
# Seconds Countdown Alarm with Interrupt and Wake Outputs

This block is a relative alarm timer. Software places an interval, in seconds, in a 32-bit load register and enables counting. A copy of that interval, the remaining count, is then reduced by one on every one-second tick, and software can read it back at any time. When the remaining count steps from one down to zero, a sticky pending flag is raised and counting rests at zero. The pending flag drives an interrupt output when interrupt delivery is enabled and a wake-up output when wake-up is enabled. Software clears the flag by writing a one to it.

Access is through a simple single-cycle register bus: a select, a write strobe, a byte address, write data and a read-data output that follows the address combinationally. The one-second tick is a one-clock pulse that is already synchronous to the block clock. Programming an interval of zero leaves the alarm inert, which is how software cancels an alarm before it loads a new one.

Top module: `cda_top`

## Requirements
- R1: After a synchronous active-low reset the load value, remaining count, count enable, interrupt enable, wake enable and pending flag are all zero, and `irq` and `wakeup` are low.
- R2: The load register at offset 0x20 stores all 32 bits written to it and reads them back unchanged.
- R3: Writing 1 to bit 0 of offset 0x28 while counting is disabled enables counting and copies the load register into the remaining count (readable at offset 0x24); bit 0 of 0x28 reads back the enable.
- R4: A write to offset 0x20 while counting is enabled also copies the new value into the remaining count; the same write while counting is disabled leaves the remaining count unchanged.
- R5: Each tick that arrives while counting is enabled and the count is non-zero lowers the remaining count by exactly one; ticks while counting is disabled leave it unchanged.
- R6: The tick that takes the count from 1 to 0 sets the pending flag (bit 0 of offset 0x30); the count then stays at 0 on further ticks and pending is not raised again after it has been cleared.
- R7: An interval of zero copied into the remaining count never raises the pending flag, whatever ticks follow.
- R8: Writing a 1 to bit 0 of offset 0x30 clears the pending flag, writing a 0 there has no effect, and an expiry in the same cycle as a clearing write leaves the flag set.
- R9: `irq` is high exactly when the pending flag and bit 0 of offset 0x2C (interrupt enable) are both set.
- R10: `wakeup` is high exactly when the pending flag and bit 0 of offset 0x50 (wake enable) are both set.
- R11: Disabling counting does not clear the pending flag.
- R12: Offsets outside 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x50 read as zero and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-clock pulse per elapsed second |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | High for a write, low for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Alarm interrupt request |
| wakeup | output | 1 | Alarm wake-up request |

## Verification
The countdown is driven with a short interval reloaded by a rising enable, an interval replaced mid-count by a load write, a zero interval and the all-ones interval; these separate the two reload paths from plain decrementing, tell a correct one-to-zero expiry from one that fires on a zero count, and expose a wrong wrap at the top of the range. Ticks applied while disabled and after expiry show that the count holds and pending fires only once. The pending flag is exercised against a zero write, a one write, a disable of counting and a clear that coincides with expiry, which distinguishes true write-one-to-clear with set priority from level clears or clears on any write. Both enables are toggled independently so `irq` and `wakeup` are each seen gated and ungated.

// File: rtl/cda_pkg.sv
// Package: register offsets and shared configuration type of the
// countdown alarm. Assumes byte addressing with 32-bit registers.
package cda_pkg;
    localparam int unsigned OFF_LOAD    = 32'h20;
    localparam int unsigned OFF_CURRENT = 32'h24;
    localparam int unsigned OFF_CNT_EN  = 32'h28;
    localparam int unsigned OFF_IRQ_EN  = 32'h2C;
    localparam int unsigned OFF_PEND    = 32'h30;
    localparam int unsigned OFF_WAKE_EN = 32'h50;

    typedef struct packed {
        logic cnt_en;
        logic irq_en;
        logic wake_en;
    } cda_cfg_t;
endpackage

// File: rtl/cda_counter.sv
// Module: cda_counter
// Holds the remaining seconds count. A reload request has priority over
// a tick; a tick while enabled lowers a non-zero count by one. Flags the
// expiry when a tick takes the count from one to zero.
// Assumes: sec_tick is a single-cycle pulse synchronous to clk.
module cda_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              sec_tick,
    input  logic              reload,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count,
    output logic              expire
);
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ZERO = '0;

    logic step;

    // Decide whether this cycle consumes a second.
    always_comb begin
        step   = cnt_en && sec_tick && !reload && (count != ZERO);
        expire = step && (count == ONE);
    end

    // Update the remaining count: reload first, else decrement on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
        end else if (reload) begin
            count <= reload_val;
        end else if (step) begin
            count <= count - ONE;
        end
    end

    // R5
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && sec_tick && !reload && count != ZERO) |=> (count == $past(count) - ONE));

    // R6
    cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == ZERO && !reload) |=> (count == ZERO));

    // R3
    cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == $past(reload_val)));
endmodule

// File: rtl/cda_regs.sv
// Module: cda_regs
// Register file of the alarm: load value, three enables and the sticky
// pending flag, with address decode and read-back multiplexing.
// Produces the reload request for the counter.
// Assumes: one access per cycle, reads have no side effects.
module cda_regs
    import cda_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] count,
    input  logic              expire,
    output cda_cfg_t          cfg,
    output logic              pending,
    output logic              reload,
    output logic [DATA_W-1:0] reload_val
);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);
    localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFF_CURRENT);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_CNT_EN);
    localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFF_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(OFF_WAKE_EN);

    logic [DATA_W-1:0] load_q;
    logic wr, wr_load, wr_en, wr_ie, wr_pend, wr_wake, clr_req, en_rise;

    // Decode write strobes per register.
    always_comb begin
        wr      = bus_sel && bus_wr;
        wr_load = wr && (bus_addr == A_LOAD);
        wr_en   = wr && (bus_addr == A_EN);
        wr_ie   = wr && (bus_addr == A_IE);
        wr_pend = wr && (bus_addr == A_PEND);
        wr_wake = wr && (bus_addr == A_WAKE);
        clr_req = wr_pend && bus_wdata[0];
        en_rise = wr_en && bus_wdata[0] && !cfg.cnt_en;
    end

    // Form the reload request and the value it carries.
    always_comb begin
        reload     = en_rise || (wr_load && cfg.cnt_en);
        reload_val = wr_load ? bus_wdata : load_q;
    end

    // Store the load interval.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (wr_load) load_q <= bus_wdata;
    end

    // Store the three enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (wr_en)   cfg.cnt_en  <= bus_wdata[0];
            if (wr_ie)   cfg.irq_en  <= bus_wdata[0];
            if (wr_wake) cfg.wake_en <= bus_wdata[0];
        end
    end

    // Sticky pending flag: expiry sets and wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (expire)  pending <= 1'b1;
        else if (clr_req) pending <= 1'b0;
    end

    // Read-back multiplexer; unmapped offsets return zero.
    always_comb begin
        unique case (bus_addr)
            A_LOAD:  bus_rdata = load_q;
            A_CUR:   bus_rdata = count;
            A_EN:    bus_rdata = DATA_W'(cfg.cnt_en);
            A_IE:    bus_rdata = DATA_W'(cfg.irq_en);
            A_PEND:  bus_rdata = DATA_W'(pending);
            A_WAKE:  bus_rdata = DATA_W'(cfg.wake_en);
            default: bus_rdata = '0;
        endcase
    end

    // R6
    pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(expire));

    // R8
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !expire) |=> !pending);

    // R11
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire && !clr_req) |=> (pending == $past(pending)));
endmodule

// File: rtl/cda_top.sv
// Module: cda_top
// Seconds countdown alarm: register file plus counter, with interrupt
// and wake-up outputs gated from the sticky pending flag.
// Assumes: sec_tick and the bus are synchronous to clk.
module cda_top #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wakeup
);
    import cda_pkg::*;

    cda_cfg_t          cfg;
    logic              pending, reload, expire;
    logic [DATA_W-1:0] reload_val, count;

    cda_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .expire(expire),
        .cfg(cfg), .pending(pending),
        .reload(reload), .reload_val(reload_val)
    );

    cda_counter #(.DATA_W(DATA_W)) u_counter (
        .clk(clk), .rst_n(rst_n),
        .cnt_en(cfg.cnt_en), .sec_tick(sec_tick),
        .reload(reload), .reload_val(reload_val),
        .count(count), .expire(expire)
    );

    // Gate the pending flag onto the two request outputs.
    always_comb begin
        irq    = pending && cfg.irq_en;
        wakeup = pending && cfg.wake_en;
    end

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pending && cfg.irq_en));

    // R10
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup |-> (pending && cfg.wake_en));
endmodule

// File: tb/cda_top_bench.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them against the design outputs.
module cda_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wakeup;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 read, 1 irq, 2 wakeup
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    event  chk_ev;

    cda_top u_cda_top (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wakeup(wakeup)
    );

    always #10 clk = ~clk;

    // Monitor: pop each expected item and compare with the live output.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                act = (it.kind == 0) ? bus_rdata :
                      (it.kind == 1) ? 32'(irq) : 32'(wakeup);
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input bit with_tick);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        sec_tick = with_tick;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic push(input int k, input logic [31:0] e, input string t);
        item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        exp_q.push_back(it);
        #2;
        ->chk_ev;
        #1;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        push(0, e, t);
        bus_sel = 1'b0;
    endtask

    task automatic pin_chk(input int k, input logic e, input string t);
        @(negedge clk);
        push(k, 32'(e), t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd_chk(8'h20, 0, "R1 load");
        rd_chk(8'h24, 0, "R1 current");
        rd_chk(8'h28, 0, "R1 enable");
        rd_chk(8'h30, 0, "R1 pending");
        pin_chk(1, 0, "R1 irq");
        pin_chk(2, 0, "R1 wakeup");
        @(negedge clk); rst_n = 1'b1;

        // R2 full-width load readback; R4 no reload while disabled
        wr_reg(8'h20, 32'hA5A5_1234, 0);
        rd_chk(8'h20, 32'hA5A5_1234, "R2 readback");
        rd_chk(8'h24, 0, "R4 disabled load write");
        ticks(3);
        rd_chk(8'h24, 0, "R5 ticks while disabled");

        // R3 rising enable reloads
        wr_reg(8'h20, 5, 0);
        wr_reg(8'h28, 1, 0);
        rd_chk(8'h24, 5, "R3 reload on enable");
        rd_chk(8'h28, 1, "R3 enable readback");
        ticks(2);
        rd_chk(8'h24, 3, "R5 two ticks");
        wr_reg(8'h20, 4, 0);
        rd_chk(8'h24, 4, "R4 reload while enabled");
        ticks(3);
        rd_chk(8'h24, 1, "R5 count at one");
        rd_chk(8'h30, 0, "R6 not yet pending");
        wr_reg(8'h2C, 1, 0);
        pin_chk(1, 0, "R9 irq without pending");
        ticks(1);
        rd_chk(8'h24, 0, "R6 count zero");
        rd_chk(8'h30, 1, "R6 pending set");
        pin_chk(1, 1, "R9 irq high");
        pin_chk(2, 0, "R10 wakeup gated");
        ticks(2);
        rd_chk(8'h24, 0, "R6 stays at zero");
        wr_reg(8'h30, 0, 0);
        rd_chk(8'h30, 1, "R8 zero write ignored");
        wr_reg(8'h50, 1, 0);
        pin_chk(2, 1, "R10 wakeup high");
        wr_reg(8'h28, 0, 0);
        rd_chk(8'h30, 1, "R11 pending after disable");
        pin_chk(1, 1, "R11 irq after disable");
        wr_reg(8'h30, 1, 0);
        rd_chk(8'h30, 0, "R8 cleared");
        pin_chk(1, 0, "R9 irq low after clear");
        pin_chk(2, 0, "R10 wakeup low after clear");

        // R7 zero interval is inert
        wr_reg(8'h20, 0, 0);
        wr_reg(8'h28, 1, 0);
        ticks(3);
        rd_chk(8'h30, 0, "R6 R7 no repeat and zero inert");
        rd_chk(8'h24, 0, "R7 count zero");

        // R12 unmapped offsets
        wr_reg(8'h40, 32'hFFFF_FFFF, 0);
        rd_chk(8'h40, 0, "R12 unmapped read");
        rd_chk(8'h20, 0, "R12 load untouched");
        rd_chk(8'h2C, 1, "R12 irq enable untouched");

        // R3 re-enable after disabled load write
        wr_reg(8'h28, 0, 0);
        wr_reg(8'h20, 2, 0);
        rd_chk(8'h24, 0, "R4 no reload while disabled");
        wr_reg(8'h28, 1, 0);
        rd_chk(8'h24, 2, "R3 reload on re-enable");
        ticks(1);
        rd_chk(8'h24, 1, "R5 count at one again");

        // R8 expiry wins over a same-cycle clear
        wr_reg(8'h30, 1, 1);
        rd_chk(8'h30, 1, "R8 set wins over clear");
        pin_chk(1, 1, "R9 irq after set-wins");
        wr_reg(8'h30, 1, 0);

        // R5 all-ones interval
        wr_reg(8'h20, 32'hFFFF_FFFF, 0);
        ticks(1);
        rd_chk(8'h24, 32'hFFFF_FFFE, "R5 top of range");
        rd_chk(8'h30, 0, "R6 no spurious pending");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule